// File: doc/BRIEF.md
# Bidirectional Telemetry Line Sequencer

This block sequences one motor-command line that is driven out for a command frame and then listened to for a reply. Up to four channels share the line's capture resource. When the transmitter signals that a frame has left, the sequencer releases the pin to input and opens an edge-capture window for the channel picked for telemetry. The window length is the frame's send time plus a fixed reply latency and a safety margin. When the window closes, the pin is driven again. The block reports how many filtered edges were stored and moves the telemetry pick to the next eligible channel.

Without telemetry, the block enforces a quiet gap before the next frame may start. The gap depends on the protocol: motor-command frames use the send time plus latency plus a longer gap, and the LED-strip mode uses a fixed gap. All times are given in microseconds and converted with a parameter for clock cycles per microsecond. Turning the captured timestamps into a value is left to a downstream decoder, which confirms with `decode_done`.

Top module: `telem_line_seq`

## Requirements
- R1: After reset the pin is driven (`pin_drive`=1), `cap_en`=0, `rx_done`=0, `tx_ok`=1, `tel_chan`=0 and `edge_cnt`=0.
- R2: With `bidir_en`=1 and `led_mode`=0, a `tx_done` accepted in the cycle after `tx_start` releases the pin (`pin_drive`=0) and raises `cap_en`. The window closes with a one-cycle `rx_done` pulse exactly (send_us+40)×CLK_PER_US cycles after the clock edge that samples `tx_done`. At that point the pin is driven again.
- R3: With `bidir_en`=0 and `led_mode`=0, `tx_ok` first returns to 1 exactly (send_us+70)×CLK_PER_US cycles after the edge that samples `tx_done`.
- R4: With `led_mode`=1, `tx_ok` first returns to 1 exactly 50×CLK_PER_US cycles after that edge, whatever `send_us` and `bidir_en` are. No window is opened.
- R5: A channel is eligible when both its `chan_en` bit and its `cap_mask` bit are set. At each window close, `tel_chan` becomes the first eligible channel among current+1, current+2 and current+3 (modulo 4). It keeps its value when none of these is eligible.
- R6: A `cfg_load` pulse sets `tel_chan` to the lowest eligible channel, or to 0 when no channel is eligible.
- R7: Every filtered change of `line_in` inside a window counts as one edge, whether rising or falling. `edge_cnt` is cleared when a window opens, is valid when `rx_done` is high, and holds until the next window opens.
- R8: `edge_cnt` stops at 21 however many edges arrive.
- R9: A level on `line_in` that lasts fewer than FILT_LEN (3) consecutive samples produces no edge.
- R10: `tx_done` is ignored while a window is open and while idle: the window's closing time is unchanged, and `tx_ok` and `pin_drive` stay at 1 in idle.
- R11: After a window closes, `tx_ok` stays 0 until `decode_done` is seen. After that the block is idle with `tx_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Frame transmission starts (accepted only when idle) |
| tx_done | input | 1 | Frame transmission finished strobe |
| send_us | input | SEND_W | Frame send time in microseconds |
| chan_en | input | 4 | Channel enable mask |
| cap_mask | input | 4 | Channels able to capture edges |
| bidir_en | input | 1 | Request telemetry after each frame |
| led_mode | input | 1 | LED-strip protocol selected |
| cfg_load | input | 1 | Load the lowest eligible channel as telemetry channel |
| line_in | input | 1 | Sampled level of the shared line |
| decode_done | input | 1 | Downstream decoder finished with the capture |
| pin_drive | output | 1 | 1 = pin driven as output, 0 = pin is input |
| cap_en | output | 1 | Edge capture window open |
| tel_chan | output | 2 | Channel selected for telemetry |
| rx_done | output | 1 | One-cycle pulse at window close |
| edge_cnt | output | 5 | Filtered edges stored in the last window |
| tx_ok | output | 1 | A new frame may start |

## Verification
The window and gap lengths are measured to the cycle for telemetry, for plain motor-command mode and for LED mode. A long send time in LED mode shows that the fixed gap really ignores `send_us`. Line patterns with an even number of clean toggles, with toggles past the cap and with short glitches tell the edge counting, the saturation and the filter apart. A table of enable and capability masks, including sparse, empty and non-eligible-start masks, drives the setup pick and two rotations. This shows wraparound, skipping and staying in place. A stray `tx_done` inside a window and in idle shows that the sequencing does not restart.

// File: rtl/tls_pkg.sv
// Shared types for the telemetry line sequencer.
package tls_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEND      = 3'd1,
        ST_SEND_DONE = 3'd2,
        ST_RECV      = 3'd3,
        ST_RECV_DONE = 3'd4,
        ST_HOLD      = 3'd5
    } seq_state_t;
endpackage

// File: rtl/tls_us_timer.sv
// One-shot interval timer. A load takes an interval in microseconds and
// converts it to clock cycles. The done strobe is placed so that the owner
// changes state exactly us_val*CLK_PER_US cycles after the edge one cycle
// before the load.
// Assumes us_val*CLK_PER_US >= 3 and no load while running.
module tls_us_timer #(
    parameter int CLK_PER_US = 125,
    parameter int US_W       = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [US_W-1:0] us_val,
    output logic            done
);
    localparam int CNT_W = US_W + $clog2(CLK_PER_US + 1) + 2;
    localparam int LAT   = 2;

    logic [CNT_W-1:0] cnt;
    logic             running;

    // Count down the loaded interval; stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= CNT_W'(us_val) * CNT_W'(CLK_PER_US) - CNT_W'(LAT);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign done = running && (cnt == '0);

    // R2: a fresh interval never ends in the cycle right after loading.
    a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
endmodule

// File: rtl/tls_edge_cap.sv
// Edge capture for the telemetry window. The line is qualified by a
// run-length filter: the filtered level changes only after FILT_LEN
// consecutive equal samples. Each change is one edge, of either polarity.
// The edge count saturates at MAX_EDGES. Assumes the idle line level is high.
module tls_edge_cap #(
    parameter int FILT_LEN  = 3,
    parameter int MAX_EDGES = 21,
    localparam int CNT_W    = $clog2(MAX_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             line_in,
    output logic [CNT_W-1:0] count
);
    logic [FILT_LEN-1:0] hist;
    logic                filt;
    logic                edge_stb;

    assign edge_stb = en && (((&hist) && !filt) || ((~|hist) && filt));

    // Shift line samples in during the window; park at idle-high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hist <= '1;
            filt <= 1'b1;
        end else begin
            hist <= {hist[FILT_LEN-2:0], line_in};
            if (edge_stb) filt <= ~filt;
        end
    end

    // Count qualified edges with saturation; clear when a window opens.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (edge_stb && count < CNT_W'(MAX_EDGES))
            count <= count + 1'b1;
    end

    // R8: the count never passes the cap.
    a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_EDGES));
    // R7: outside a window the count holds.
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(count));
    // R9: a change of filtered level needs the line to agree with it.
    a_r9_filter_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $changed(filt)) |-> (filt == $past(line_in)));
endmodule

// File: rtl/tls_chan_rotator.sv
// Telemetry channel selector. On init it picks the lowest eligible channel,
// or channel 0 if none is eligible. On advance it steps to the nearest
// eligible channel after the current one, modulo NCH. It keeps the current
// channel when no other channel is eligible.
module tls_chan_rotator #(
    parameter int NCH      = 4,
    localparam int CH_W    = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  eligible,
    input  logic            init,
    input  logic            advance,
    output logic [CH_W-1:0] chan
);
    logic [CH_W-1:0] nxt_rot;
    logic [CH_W-1:0] nxt_low;

    // Nearest eligible successor; descending scan so the smallest step wins.
    always_comb begin
        nxt_rot = chan;
        for (int i = NCH - 1; i >= 1; i--) begin
            if (eligible[(int'(chan) + i) % NCH])
                nxt_rot = CH_W'((int'(chan) + i) % NCH);
        end
    end

    // Lowest eligible channel; descending scan so the lowest index wins.
    always_comb begin
        nxt_low = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eligible[i]) nxt_low = CH_W'(i);
        end
    end

    // Selection register.
    always_ff @(posedge clk) begin
        if (!rst_n)       chan <= '0;
        else if (init)    chan <= nxt_low;
        else if (advance) chan <= nxt_rot;
    end

    // R5: a rotation only moves to an eligible channel.
    a_r5_rot_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !init && $stable(eligible)) |=> (chan == $past(chan)) || eligible[chan]);
    // R6: setup with any eligible channel lands on an eligible one.
    a_r6_init_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (init && (|eligible)) |=> eligible[chan]);
endmodule

// File: rtl/telem_line_seq.sv
// Top of the bidirectional telemetry line sequencer. It runs the frame
// sequence IDLE -> SEND -> SEND_DONE -> RECV -> RECV_DONE -> IDLE, or
// SEND_DONE -> HOLD -> IDLE when no telemetry is taken. It sizes the receive
// window and the quiet gap from the send time, owns the pin direction and
// drives capture and channel rotation.
// Assumes tx_done follows tx_start, and that the masks stay steady during a frame.
module telem_line_seq #(
    parameter int CLK_PER_US = 125,
    parameter int SEND_W     = 10,
    parameter int NCH        = 4,
    parameter int REPLY_US   = 30,
    parameter int MARGIN_US  = 10,
    parameter int GAP_US     = 40,
    parameter int LED_GAP_US = 50,
    parameter int FILT_LEN   = 3,
    parameter int MAX_EDGES  = 21
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tx_start,
    input  logic                             tx_done,
    input  logic [SEND_W-1:0]                send_us,
    input  logic [NCH-1:0]                   chan_en,
    input  logic [NCH-1:0]                   cap_mask,
    input  logic                             bidir_en,
    input  logic                             led_mode,
    input  logic                             cfg_load,
    input  logic                             line_in,
    input  logic                             decode_done,
    output logic                             pin_drive,
    output logic                             cap_en,
    output logic [$clog2(NCH)-1:0]           tel_chan,
    output logic                             rx_done,
    output logic [$clog2(MAX_EDGES+1)-1:0]   edge_cnt,
    output logic                             tx_ok
);
    import tls_pkg::*;

    localparam int US_W = SEND_W + 2;

    seq_state_t      state;
    logic            tmr_load;
    logic            tmr_done;
    logic [US_W-1:0] interval_us;
    logic            take_telem;
    logic            win_close;

    assign take_telem = bidir_en && !led_mode;
    assign tmr_load   = (state == ST_SEND_DONE);
    assign win_close  = (state == ST_RECV) && tmr_done;
    assign tx_ok      = (state == ST_IDLE);

    // Interval chosen by mode: receive window, LED gap or command gap.
    always_comb begin
        if (led_mode)
            interval_us = US_W'(LED_GAP_US);
        else if (bidir_en)
            interval_us = US_W'(send_us) + US_W'(REPLY_US + MARGIN_US);
        else
            interval_us = US_W'(send_us) + US_W'(REPLY_US + GAP_US);
    end

    // Frame sequence state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:      if (tx_start) state <= ST_SEND;
                ST_SEND:      if (tx_done) state <= ST_SEND_DONE;
                ST_SEND_DONE: state <= take_telem ? ST_RECV : ST_HOLD;
                ST_RECV:      if (tmr_done) state <= ST_RECV_DONE;
                ST_RECV_DONE: if (decode_done) state <= ST_IDLE;
                ST_HOLD:      if (tmr_done) state <= ST_IDLE;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    // Pin direction and capture enable, turned around at window edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_drive <= 1'b1;
            cap_en    <= 1'b0;
        end else if (state == ST_SEND_DONE && take_telem) begin
            pin_drive <= 1'b0;
            cap_en    <= 1'b1;
        end else if (win_close) begin
            pin_drive <= 1'b1;
            cap_en    <= 1'b0;
        end
    end

    // Receive-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_done <= 1'b0;
        else        rx_done <= win_close;
    end

    tls_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .us_val(interval_us), .done(tmr_done)
    );

    tls_edge_cap #(.FILT_LEN(FILT_LEN), .MAX_EDGES(MAX_EDGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(cap_en),
        .clear(state == ST_SEND_DONE && take_telem),
        .line_in(line_in), .count(edge_cnt)
    );

    tls_chan_rotator #(.NCH(NCH)) u_rot (
        .clk(clk), .rst_n(rst_n), .eligible(chan_en & cap_mask),
        .init(cfg_load), .advance(win_close), .chan(tel_chan)
    );

    // R2: the pin is never driven while capture is open.
    a_r2_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !pin_drive);
    // R2: receive-complete is a single-cycle pulse ending an open window.
    a_r2_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ($past(cap_en) && !cap_en) ##1 !rx_done);
    // R10: a stray tx_done inside the window does not restart the sequence.
    a_r10_txdone_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && tx_done && !tmr_done) |=> (state == ST_RECV));
    // R11: no new frame until the decoder has confirmed.
    a_r11_wait_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV_DONE && !decode_done) |=> !tx_ok);
    // R4: LED mode never opens a capture window.
    a_r4_led_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND_DONE && led_mode) |=> !cap_en);
endmodule

// File: tb/tb_telem_line_seq.sv
module tb_telem_line_seq;
    localparam int CPU = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0, tx_done = 1'b0, bidir_en = 1'b0, led_mode = 1'b0;
    logic       cfg_load = 1'b0, line_in = 1'b1, decode_done = 1'b0;
    logic [9:0] send_us = '0;
    logic [3:0] chan_en = 4'hF, cap_mask = 4'hF;
    logic       pin_drive, cap_en, rx_done, tx_ok;
    logic [1:0] tel_chan;
    logic [4:0] edge_cnt;

    int cyc = 0;
    int tests = 0;
    int fails = 0;

    telem_line_seq #(.CLK_PER_US(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_done(tx_done),
        .send_us(send_us), .chan_en(chan_en), .cap_mask(cap_mask),
        .bidir_en(bidir_en), .led_mode(led_mode), .cfg_load(cfg_load),
        .line_in(line_in), .decode_done(decode_done), .pin_drive(pin_drive),
        .cap_en(cap_en), .tel_chan(tel_chan), .rx_done(rx_done),
        .edge_cnt(edge_cnt), .tx_ok(tx_ok)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One frame: start, finish, optional line pattern, then wait for close or gap end.
    task automatic frame(input int us, input int toggles, input bit glitch,
                         input bit stray, output int n, output int cnt);
        int t0;
        bit telem;
        telem = bidir_en && !led_mode;
        send_us = 10'(us);
        @(negedge clk) tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0; tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        t0 = cyc;
        repeat (3) @(negedge clk);
        if (glitch) begin
            line_in = 1'b0; @(negedge clk); line_in = 1'b1; repeat (5) @(negedge clk);
            line_in = 1'b0; repeat (2) @(negedge clk); line_in = 1'b1; repeat (5) @(negedge clk);
            line_in = 1'b0; repeat (5) @(negedge clk); line_in = 1'b1; repeat (5) @(negedge clk);
        end
        for (int i = 0; i < toggles; i++) begin
            line_in = ~line_in;
            repeat (6) @(negedge clk);
            if (stray && i == 0) begin
                tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
            end
        end
        line_in = 1'b1;
        while (!(telem ? rx_done : tx_ok)) @(negedge clk);
        n = cyc - t0;
        cnt = int'(edge_cnt);
        if (telem) begin
            check(!tx_ok && pin_drive, "R11 tx_ok low after close", int'(tx_ok), 0);
            @(negedge clk);
            check(!tx_ok, "R11 waits for decode_done", int'(tx_ok), 0);
            decode_done = 1'b1;
            @(negedge clk) decode_done = 1'b0;
            check(tx_ok, "R11 idle after decode_done", int'(tx_ok), 1);
        end
    endtask

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] cap;
        logic [1:0] c0;
        logic [1:0] c1;
        logic [1:0] c2;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'b1111, 4'b1111, 2'd0, 2'd1, 2'd2},
        '{4'b1010, 4'b1111, 2'd1, 2'd3, 2'd1},
        '{4'b0110, 4'b1011, 2'd1, 2'd1, 2'd1},
        '{4'b0000, 4'b1111, 2'd0, 2'd0, 2'd0},
        '{4'b1100, 4'b0111, 2'd2, 2'd2, 2'd2},
        '{4'b1001, 4'b1001, 2'd0, 2'd3, 2'd0},
        '{4'b1000, 4'b1111, 2'd3, 2'd3, 2'd3}
    };

    initial begin
        int n, cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pin_drive == 1'b1 && cap_en == 1'b0, "R1 pin/cap", {pin_drive, cap_en}, 2);
        check(tx_ok == 1'b1 && rx_done == 1'b0, "R1 tx_ok/rx_done", {tx_ok, rx_done}, 2);
        check(tel_chan == 2'd0 && edge_cnt == 5'd0, "R1 chan/count", {tel_chan, edge_cnt}, 0);

        // R10 tx_done while idle is ignored
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_ok && pin_drive && !cap_en, "R10 idle tx_done", {tx_ok, pin_drive, cap_en}, 6);

        // Vector table: setup pick and two rotations (R5, R6)
        bidir_en = 1'b1;
        foreach (VECS[k]) begin
            chan_en = VECS[k].en; cap_mask = VECS[k].cap;
            @(negedge clk) cfg_load = 1'b1;
            @(negedge clk) cfg_load = 1'b0;
            check(tel_chan == VECS[k].c0, "R6 setup pick", tel_chan, VECS[k].c0);
            frame(0, 0, 0, 0, n, cnt);
            check(tel_chan == VECS[k].c1, "R5 first rotation", tel_chan, VECS[k].c1);
            frame(0, 0, 0, 0, n, cnt);
            check(tel_chan == VECS[k].c2, "R5 second rotation", tel_chan, VECS[k].c2);
        end
        chan_en = 4'hF; cap_mask = 4'hF;

        // R2 window timing and turnaround; R7 edge count of both polarities
        fork
            begin
                frame(5, 4, 0, 0, n, cnt);
            end
            begin
                repeat (5) @(negedge clk);
                check(!pin_drive && cap_en, "R2 pin released in window", {pin_drive, cap_en}, 1);
            end
        join
        check(n == 45 * CPU, "R2 window length", n, 45 * CPU);
        check(cnt == 4, "R7 edge count", cnt, 4);
        check(pin_drive, "R2 pin driven after close", pin_drive, 1);
        repeat (4) @(negedge clk);
        check(edge_cnt == 5'd4, "R7 count held after close", edge_cnt, 4);

        // R8 saturation
        frame(100, 30, 0, 0, n, cnt);
        check(cnt == 21, "R8 edge cap", cnt, 21);

        // R9 glitch rejection: only one clean low pulse counts
        frame(0, 0, 1, 0, n, cnt);
        check(cnt == 2, "R9 glitch filter", cnt, 2);

        // R10 stray tx_done inside window
        frame(20, 2, 0, 1, n, cnt);
        check(n == 60 * CPU, "R10 window unchanged by stray tx_done", n, 60 * CPU);

        // R3 command-mode quiet gap
        bidir_en = 1'b0;
        frame(5, 0, 0, 0, n, cnt);
        check(n == 75 * CPU, "R3 command gap", n, 75 * CPU);
        check(pin_drive, "R3 pin stays driven", pin_drive, 1);

        // R4 LED mode gap, independent of send time and bidir flag
        led_mode = 1'b1;
        frame(5, 0, 0, 0, n, cnt);
        check(n == 50 * CPU, "R4 LED gap short send", n, 50 * CPU);
        bidir_en = 1'b1;
        frame(200, 0, 0, 0, n, cnt);
        check(n == 50 * CPU, "R4 LED gap ignores send_us and bidir", n, 50 * CPU);
        check(!cap_en && pin_drive, "R4 no window in LED mode", {cap_en, pin_drive}, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule